// File: doc/BRIEF.md
# Return Stack and External Interrupt Controller

This block is the control-flow unit of a small 4-bit microcontroller core. Decode hands it one strobe per executed flow-control instruction: subroutine call, plain return, return-and-skip, return-from-interrupt, interrupt enable and disable, and the choice of the interrupt's active edge. The return addresses live in a hardware last-in-first-out stack whose depth is a parameter. On every redirect the unit loads a new program counter into fetch. On return-and-skip it also tells fetch to discard the instruction at the return address.

One external interrupt pin passes through a two-flop synchronizer and then an edge detector. The detector's edge is selected at run time. A detected edge sets a pending latch, but only while interrupts are enabled. When the interrupt is taken, the unit pushes the return address that fetch offers on `pc_i` and clears the enable flag. It then redirects fetch to the first word of a fixed page: `INT_PAGE * 2**PAGE_W`. Return-from-interrupt pops that address and sets the enable flag again.

Top module: `flow_ctrl_unit`

## Requirements
- R1: After reset `pc_o` is 0, `pc_load_o`, `skip_o` and `int_taken_o` are 0, interrupts are disabled and the active edge is rising.
- R2: A cycle with `call_i` pushes `pc_i`. One clock later `pc_load_o` is 1 for a cycle, with `pc_o` equal to the `call_tgt_i` of the call cycle.
- R3: A cycle with `rt_i` pops the stack. One clock later `pc_load_o` is 1, with `pc_o` equal to the most recently pushed address still on the stack (last in, first out).
- R4: `rts_i` behaves as R3 and, in addition, drives `skip_o` to 1 in the same cycle as the load. In every other cycle `skip_o` is 0.
- R5: `ei_i` sets the enable flag and `di_i` clears it. When both arrive together, `di_i` wins. An edge that arrives while interrupts are disabled is discarded and never taken later.
- R6: `inth_i` selects the rising edge of `irq_pin_i` as active and `intl_i` selects the falling edge. Edges of the other direction are ignored.
- R7: Suppose an active edge reaches `irq_pin_i` while interrupts are enabled and no flow strobe is present. Then on the 4th rising clock edge after the pin change, `int_taken_o` and `pc_load_o` become 1 for one cycle, with `pc_o` = `INT_PAGE * 2**PAGE_W` (0x600 by default).
- R8: Taking an interrupt pushes `pc_i` and clears the enable flag. `rti_i` pops the stack, loads the popped address and sets the enable flag.
- R9: A call, return or return-from-interrupt strobe has priority over a pending interrupt. The interrupt stays pending and is taken in the following strobe-free cycle. If several return or call strobes arrive together, the order of precedence is call, then `rt_i`, then `rts_i`, then `rti_i`.
- R10: A push onto a full stack discards the oldest entry. A pop that goes past the oldest retained entry returns that oldest entry again. Neither case raises any error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Subroutine call strobe |
| rt_i | input | 1 | Return strobe |
| rts_i | input | 1 | Return-and-skip strobe |
| rti_i | input | 1 | Return-from-interrupt strobe |
| ei_i | input | 1 | Interrupt enable strobe |
| di_i | input | 1 | Interrupt disable strobe |
| inth_i | input | 1 | Select rising edge as active |
| intl_i | input | 1 | Select falling edge as active |
| call_tgt_i | input | PC_W | Call destination address |
| pc_i | input | PC_W | Return address offered by fetch |
| irq_pin_i | input | 1 | Asynchronous external interrupt pin |
| pc_o | output | PC_W | Program counter to load into fetch |
| pc_load_o | output | 1 | Fetch must load `pc_o` |
| skip_o | output | 1 | Fetch must discard the next instruction |
| int_taken_o | output | 1 | The interrupt vector was taken this cycle |

## Verification
A pending interrupt and a call strobe can fall in the same cycle. To provoke this, the bench changes the pin, waits three clocks, and drives a call exactly into the clock edge on which the interrupt would otherwise be taken. The bench judges the outcome in three steps:
- The call's target must load first, with `int_taken_o` low.
- The vector must follow in the next cycle, with the return address offered then.
- A return-from-interrupt and a return must then unwind both addresses in the correct order.

// File: rtl/flow_ctrl_pkg.sv
package flow_ctrl_pkg;
  typedef enum logic [2:0] {
    FLOW_NONE,
    FLOW_CALL,
    FLOW_RET,
    FLOW_RETSKIP,
    FLOW_RETI,
    FLOW_IRQ
  } flow_e;

  function automatic logic flow_pushes(flow_e f);
    return (f == FLOW_CALL) || (f == FLOW_IRQ);
  endfunction

  function automatic logic flow_pops(flow_e f);
    return (f == FLOW_RET) || (f == FLOW_RETSKIP) || (f == FLOW_RETI);
  endfunction
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rising_sel_i,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else if (g == 0) sync_q[g] <= pin_i;
      else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  logic cur;
  assign cur    = sync_q[SYNC_STAGES-1];
  assign edge_o = rising_sel_i ? (cur & ~prev_q) : (~cur & prev_q);
endmodule

// File: rtl/irq_pending.sv
module irq_pending (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  input  logic en_i,
  input  logic take_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (!en_i) pend_q <= 1'b0;
    else            pend_q <= (pend_q & ~take_i) | edge_i;
  end

  assign pend_o = pend_q;

  // R5
  pend_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pend_o);
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned W     = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] top_o
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [W-1:0] entry_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        entry_q[g] <= '0;
      end else if (push_i) begin
        if (g == 0) entry_q[g] <= push_data_i;
        else        entry_q[g] <= entry_q[(g == 0) ? 0 : g-1];
      end else if (pop_i) begin
        // bottom entry is kept so an over-pop returns the oldest address
        if (g != LAST) entry_q[g] <= entry_q[(g == LAST) ? LAST : g+1];
      end
    end
  end

  assign top_o = entry_q[0];

  // R3
  push_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> top_o == $past(push_data_i));
  // R10
  pop_keep_bottom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> entry_q[LAST] == $past(entry_q[LAST]));
endmodule

// File: rtl/flow_ctrl_unit.sv
module flow_ctrl_unit
  import flow_ctrl_pkg::*;
#(
  parameter int unsigned PC_W        = 11,
  parameter int unsigned STACK_DEPTH = 3,
  parameter int unsigned PAGE_W      = 7,
  parameter int unsigned INT_PAGE    = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            call_i,
  input  logic            rt_i,
  input  logic            rts_i,
  input  logic            rti_i,
  input  logic            ei_i,
  input  logic            di_i,
  input  logic            inth_i,
  input  logic            intl_i,
  input  logic [PC_W-1:0] call_tgt_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            irq_pin_i,
  output logic [PC_W-1:0] pc_o,
  output logic            pc_load_o,
  output logic            skip_o,
  output logic            int_taken_o
);
  localparam logic [PC_W-1:0] VEC_ADDR = PC_W'(INT_PAGE << PAGE_W);

  logic            en_q, pol_q;
  logic [PC_W-1:0] pc_q;
  logic            load_q, skip_q, taken_q;
  logic            irq_edge, pend;
  logic [PC_W-1:0] stack_top;
  flow_e           flow;

  always_comb begin
    flow = FLOW_NONE;
    if      (call_i)        flow = FLOW_CALL;
    else if (rt_i)          flow = FLOW_RET;
    else if (rts_i)         flow = FLOW_RETSKIP;
    else if (rti_i)         flow = FLOW_RETI;
    else if (pend && en_q)  flow = FLOW_IRQ;
  end

  irq_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pin_i       (irq_pin_i),
    .rising_sel_i(pol_q),
    .edge_o      (irq_edge)
  );

  irq_pending u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .edge_i(irq_edge),
    .en_i  (en_q),
    .take_i(flow == FLOW_IRQ),
    .pend_o(pend)
  );

  ret_stack #(.DEPTH(STACK_DEPTH), .W(PC_W)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (flow_pushes(flow)),
    .pop_i      (flow_pops(flow)),
    .push_data_i(pc_i),
    .top_o      (stack_top)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      load_q  <= 1'b0;
      skip_q  <= 1'b0;
      taken_q <= 1'b0;
    end else begin
      load_q  <= (flow != FLOW_NONE);
      skip_q  <= (flow == FLOW_RETSKIP);
      taken_q <= (flow == FLOW_IRQ);
      unique case (flow)
        FLOW_CALL:                         pc_q <= call_tgt_i;
        FLOW_IRQ:                          pc_q <= VEC_ADDR;
        FLOW_RET, FLOW_RETSKIP, FLOW_RETI: pc_q <= stack_top;
        default:                           pc_q <= pc_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      pol_q <= 1'b1;
    end else begin
      if      (flow == FLOW_IRQ)  en_q <= 1'b0;
      else if (flow == FLOW_RETI) en_q <= 1'b1;
      else if (di_i)              en_q <= 1'b0;
      else if (ei_i)              en_q <= 1'b1;
      if      (inth_i) pol_q <= 1'b1;
      else if (intl_i) pol_q <= 1'b0;
    end
  end

  assign pc_o        = pc_q;
  assign pc_load_o   = load_q;
  assign skip_o      = skip_q;
  assign int_taken_o = taken_q;

  // R2
  call_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_i |=> pc_load_o && pc_o == $past(call_tgt_i));
  // R4
  rts_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rts_i && !call_i && !rt_i) |=> skip_o && pc_load_o);
  // R7
  irq_vector_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && en_q && !call_i && !rt_i && !rts_i && !rti_i)
      |=> int_taken_o && pc_load_o && pc_o == VEC_ADDR);
  // R8
  irq_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_taken_o |-> !en_q);
  // R9
  strobe_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i || rt_i || rts_i || rti_i) |=> !int_taken_o);
endmodule

// File: tb/tb_flow_ctrl_unit.sv
module tb_flow_ctrl_unit;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 11;
  localparam logic [PC_W-1:0] VEC = 11'h600;

  logic clk = 0, rst_ni = 0;
  logic call_i = 0, rt_i = 0, rts_i = 0, rti_i = 0, ei_i = 0, di_i = 0, inth_i = 0, intl_i = 0;
  logic [PC_W-1:0] call_tgt_i = '0, pc_i = '0;
  logic irq_pin_i = 0;
  logic [PC_W-1:0] pc_o;
  logic pc_load_o, skip_o, int_taken_o;

  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flow_ctrl_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .call_i(call_i), .rt_i(rt_i), .rts_i(rts_i),
    .rti_i(rti_i), .ei_i(ei_i), .di_i(di_i), .inth_i(inth_i), .intl_i(intl_i),
    .call_tgt_i(call_tgt_i), .pc_i(pc_i), .irq_pin_i(irq_pin_i),
    .pc_o(pc_o), .pc_load_o(pc_load_o), .skip_o(skip_o), .int_taken_o(int_taken_o)
  );

  // op: 0 none, 1 call, 2 rt, 3 rts
  typedef struct packed {
    logic [1:0]      op;
    logic [PC_W-1:0] tgt;
    logic [PC_W-1:0] pcin;
    logic            eload;
    logic [PC_W-1:0] epc;
    logic            eskip;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 11'h100, 11'h011, 1'b1, 11'h100, 1'b0},
    '{2'd1, 11'h200, 11'h101, 1'b1, 11'h200, 1'b0},
    '{2'd2, 11'h000, 11'h000, 1'b1, 11'h101, 1'b0},
    '{2'd3, 11'h000, 11'h000, 1'b1, 11'h011, 1'b1},
    '{2'd0, 11'h000, 11'h000, 1'b0, 11'h000, 1'b0},
    '{2'd1, 11'h300, 11'h0A1, 1'b1, 11'h300, 1'b0},
    '{2'd1, 11'h310, 11'h0A2, 1'b1, 11'h310, 1'b0},
    '{2'd1, 11'h320, 11'h0A3, 1'b1, 11'h320, 1'b0},
    '{2'd1, 11'h330, 11'h0A4, 1'b1, 11'h330, 1'b0},
    '{2'd2, 11'h000, 11'h000, 1'b1, 11'h0A4, 1'b0},
    '{2'd3, 11'h000, 11'h000, 1'b1, 11'h0A3, 1'b1},
    '{2'd2, 11'h000, 11'h000, 1'b1, 11'h0A2, 1'b0},
    '{2'd2, 11'h000, 11'h000, 1'b1, 11'h0A2, 1'b0},
    '{2'd3, 11'h000, 11'h000, 1'b1, 11'h0A2, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_strobes();
    call_i = 0; rt_i = 0; rts_i = 0; rti_i = 0;
    ei_i = 0; di_i = 0; inth_i = 0; intl_i = 0;
  endtask

  // returns number of clocks until int_taken_o, or 0 if none within limit
  task automatic wait_take(input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      step();
      if (int_taken_o && n == 0) n = i;
    end
  endtask

  task automatic take_check(input string req, input logic [PC_W-1:0] ret_pc);
    pc_i = ret_pc;
    for (int i = 1; i <= 4; i++) begin
      step();
      if (i < 4) chk(req, int_taken_o, 0);
    end
    chk(req, int_taken_o, 1);
    chk(req, pc_load_o, 1);
    chk(req, pc_o, VEC);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int n;
    string req;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", pc_o, 0);
    chk("R1", pc_load_o, 0);
    chk("R1", skip_o, 0);
    chk("R1", int_taken_o, 0);

    // table: call/return sequences
    for (int i = 0; i < NV; i++) begin
      clear_strobes();
      call_i = (VECS[i].op == 2'd1);
      rt_i   = (VECS[i].op == 2'd2);
      rts_i  = (VECS[i].op == 2'd3);
      call_tgt_i = VECS[i].tgt;
      pc_i       = VECS[i].pcin;
      step();
      clear_strobes();
      case (VECS[i].op)
        2'd1: req = "R2";
        2'd2: req = "R3";
        2'd3: req = "R4";
        default: req = "R4";
      endcase
      if (i >= 12) req = "R10";
      chk(req, pc_load_o, VECS[i].eload);
      chk(req, skip_o, VECS[i].eskip);
      if (VECS[i].eload) chk(req, pc_o, VECS[i].epc);
    end

    // R5 disabled after reset: rising edge ignored, even after later EI
    irq_pin_i = 1;
    wait_take(8, n);
    chk("R5", n, 0);
    ei_i = 1; step(); clear_strobes();
    wait_take(6, n);
    chk("R5", n, 0);

    // R6 falling edge ignored while rising selected
    irq_pin_i = 0;
    wait_take(8, n);
    chk("R6", n, 0);

    // R7 rising edge taken on 4th clock, vector page
    irq_pin_i = 1;
    take_check("R7", 11'h155);

    // R8 enable cleared by take: next edge ignored
    irq_pin_i = 0; step(); step();
    irq_pin_i = 1;
    wait_take(8, n);
    chk("R8", n, 0);

    // R8 RTI returns and re-enables
    rti_i = 1; step(); clear_strobes();
    chk("R8", pc_load_o, 1);
    chk("R8", pc_o, 11'h155);
    irq_pin_i = 0; step(); step();
    irq_pin_i = 1;
    take_check("R8", 11'h166);
    rti_i = 1; step(); clear_strobes();
    chk("R8", pc_o, 11'h166);

    // R6 falling edge selected
    intl_i = 1; step(); clear_strobes();
    irq_pin_i = 0;
    take_check("R6", 11'h177);
    rti_i = 1; step(); clear_strobes();
    chk("R6", pc_o, 11'h177);
    irq_pin_i = 1;
    wait_take(8, n);
    chk("R6", n, 0);

    // R9 call coincides with pending interrupt
    irq_pin_i = 0;
    step(); step(); step();
    call_i = 1; call_tgt_i = 11'h2AA; pc_i = 11'h0C0;
    step(); clear_strobes();
    chk("R9", pc_load_o, 1);
    chk("R9", pc_o, 11'h2AA);
    chk("R9", int_taken_o, 0);
    pc_i = 11'h2AB;
    step();
    chk("R9", int_taken_o, 1);
    chk("R9", pc_o, VEC);
    rti_i = 1; step(); clear_strobes();
    chk("R9", pc_o, 11'h2AB);
    rt_i = 1; step(); clear_strobes();
    chk("R9", pc_o, 11'h0C0);

    // R5 DI wins over EI; edge then ignored
    di_i = 1; ei_i = 1; step(); clear_strobes();
    irq_pin_i = 1; step(); step();
    irq_pin_i = 0;
    wait_take(8, n);
    chk("R5", n, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule